// File: doc/BRIEF.md
# 8-bit ALU with Exact Flag Generation

This block is the arithmetic and logic stage of an 8-bit processor datapath. On every clock it takes an operation code, the accumulator, a second operand, the current flag byte and a bit index. It registers the 8-bit result and the new flag byte. Every flag bit is computed exactly, including the two spare bits that copy result bits 5 and 3. Compare takes those two bits from its operand. Bit test has its own rules for them.

The surrounding sequencer chooses the operation and writes the registered result and flags back wherever it needs to. The result of one operation is visible one clock after its inputs are presented. Codes that name no operation pass the accumulator and the flag byte through unchanged.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` and `flags_o` are 0. After reset, the outputs hold the value computed from the inputs sampled at the previous rising clock edge. The flag byte is laid out from bit 7 to bit 0 as sign, zero, copy of result bit 5, half carry, copy of result bit 3, parity/overflow, subtract, carry.
- R2: Op 0 (add) and op 1 (add plus flag carry, flags_i bit 0) put acc+opnd(+carry) on the result. S, Z and the bit 5/3 copies come from the result. H is the carry from bit 3 into bit 4, P/V is signed overflow, N=0 and C is the carry out of bit 7.
- R3: Op 2 (subtract) and op 3 (subtract minus flag carry) put acc-opnd(-carry) on the result. H is the borrow from bit 4, P/V is signed overflow, N=1 and C is the borrow out of bit 7.
- R4: Op 4 (compare) computes the op 2 flags, except that the bit 5 and bit 3 copies are taken from opnd. The result output equals acc.
- R5: Op 5 (increment) and op 6 (decrement) operate on opnd. Their flags are those of an add or subtract of 1, with N set by direction, and C copied from flags_i bit 0.
- R6: Op 7 (negate) computes 0-acc with subtract flags. N=1, C=1 whenever acc is not 0, and P/V=1 only for acc=0x80.
- R7: Op 8 (AND), op 9 (OR) and op 10 (XOR) combine acc with opnd. H is 1 for AND and 0 otherwise. N=0, C=0, and P/V is 1 when the result has an even number of ones.
- R8: Ops 11 to 18 act on opnd: rotate left circular, rotate right circular, rotate left through carry, rotate right through carry, shift left with 0 in bit 0, shift right keeping bit 7, shift left with 1 in bit 0, and shift right with 0 in bit 7. C is the bit shifted out, H=0, N=0, P/V is even parity, and S, Z and the bit copies come from the result.
- R9: Ops 19 to 22 are the left-circular, right-circular, left-through-carry and right-through-carry rotates of acc. They set the bit 5/3 copies from the result, H=0, N=0 and C to the bit shifted out, and keep S, Z and P/V from flags_i.
- R10: Op 23 (bit test) examines opnd bit bit_sel_i and outputs result=acc. Z and P/V are 1 when the bit is 0. S is 1 only for index 7 with the bit set. The bit 5 and bit 3 copies are 1 only for index 5 or index 3 respectively with the bit set. H=1, N=0, and C comes from flags_i.
- R11: Op 24 (decimal adjust) corrects acc using flags_i H, N and C. The low correction of 6 applies when the low nibble exceeds 9 or H is set. The high correction of 0x60 applies, and sets C, when C is set or acc exceeds 0x99. Both corrections are added when N=0 and subtracted when N=1. H becomes low-nibble>9 after an add, or old H with low nibble<6 after a subtract. N is kept and P/V is even parity.
- R12: Op codes 25 to 31 give result=acc and flags=flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand or single operand |
| flags_i | input | 8 | Current flag byte |
| bit_sel_i | input | 3 | Bit index for bit test |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered new flag byte |

## Verification
The checker relates each registered output to the operation code and inputs of the previous clock. It assumes that the inputs are held steady around the rising edge and carry a meaningful value on every cycle, since no qualifier marks idle cycles. The stimulus changes inputs only on falling edges. It walks the overflow, borrow, zero and nibble-boundary values directed at each operation, sweeps every bit index, and mixes in random codes that include the unassigned ones, so every cycle carries a well-defined operation.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int DW     = 8;
    localparam int OPW    = 5;
    localparam int IDXW   = $clog2(DW);
    localparam int F_S    = 7;
    localparam int F_Z    = 6;
    localparam int F_B5   = 5;
    localparam int F_H    = 4;
    localparam int F_B3   = 3;
    localparam int F_PV   = 2;
    localparam int F_N    = 1;
    localparam int F_C    = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CP   = 5'd4,  OP_INC  = 5'd5,  OP_DEC  = 5'd6,  OP_NEG  = 5'd7,
        OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_RLC  = 5'd11,
        OP_RRC  = 5'd12, OP_RL   = 5'd13, OP_RR   = 5'd14, OP_SLA  = 5'd15,
        OP_SRA  = 5'd16, OP_SLL  = 5'd17, OP_SRL  = 5'd18, OP_RLCA = 5'd19,
        OP_RRCA = 5'd20, OP_RLA  = 5'd21, OP_RRA  = 5'd22, OP_BIT  = 5'd23,
        OP_DAA  = 5'd24
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [7:0]    flg;
    } alu_state_t;

    function automatic logic even_par(input logic [DW-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/fa_arith.sv
module fa_arith
    import fa_pkg::*;
(
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          ci_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          half_o,
    output logic          carry_o,
    output logic          ovf_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] y_eff;
    logic          c_eff;
    logic [DW:0]   full;
    logic [HW:0]   low;

    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        c_eff   = sub_i ? ~ci_i : ci_i;
        full    = {1'b0, x_i} + {1'b0, y_eff} + {{DW{1'b0}}, c_eff};
        low     = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        sum_o   = full[DW-1:0];
        half_o  = sub_i ? ~low[HW] : low[HW];
        carry_o = sub_i ? ~full[DW] : full[DW];
        ovf_o   = (x_i[DW-1] == y_eff[DW-1]) && (full[DW-1] != x_i[DW-1]);
    end
endmodule

// File: rtl/fa_shift.sv
module fa_shift
    import fa_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] v_i,
    input  logic          cin_i,
    output logic [DW-1:0] r_o,
    output logic          cout_o
);
    always_comb begin
        r_o    = v_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_RLC, OP_RLCA: begin r_o = {v_i[DW-2:0], v_i[DW-1]}; cout_o = v_i[DW-1]; end
            OP_RRC, OP_RRCA: begin r_o = {v_i[0], v_i[DW-1:1]};    cout_o = v_i[0];    end
            OP_RL,  OP_RLA:  begin r_o = {v_i[DW-2:0], cin_i};     cout_o = v_i[DW-1]; end
            OP_RR,  OP_RRA:  begin r_o = {cin_i, v_i[DW-1:1]};     cout_o = v_i[0];    end
            OP_SLA:          begin r_o = {v_i[DW-2:0], 1'b0};      cout_o = v_i[DW-1]; end
            OP_SLL:          begin r_o = {v_i[DW-2:0], 1'b1};      cout_o = v_i[DW-1]; end
            OP_SRA:          begin r_o = {v_i[DW-1], v_i[DW-1:1]}; cout_o = v_i[0];    end
            OP_SRL:          begin r_o = {1'b0, v_i[DW-1:1]};      cout_o = v_i[0];    end
            default: ;
        endcase
    end
endmodule

// File: rtl/fa_daa.sv
module fa_daa
    import fa_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic          h_i,
    input  logic          n_i,
    input  logic          c_i,
    output logic [DW-1:0] r_o,
    output logic          h_o,
    output logic          c_o
);
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] NIB_MAX = HW'(9);
    localparam logic [HW-1:0] NIB_FIX = HW'(6);
    localparam logic [DW-1:0] BYTE_MAX = {NIB_MAX, NIB_MAX};

    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] adj;

    always_comb begin
        lo_fix = h_i || (a_i[HW-1:0] > NIB_MAX);
        hi_fix = c_i || (a_i > BYTE_MAX);
        adj    = {hi_fix ? NIB_FIX : {HW{1'b0}}, lo_fix ? NIB_FIX : {HW{1'b0}}};
        r_o    = n_i ? (a_i - adj) : (a_i + adj);
        c_o    = hi_fix;
        h_o    = n_i ? (h_i && (a_i[HW-1:0] < NIB_FIX)) : (a_i[HW-1:0] > NIB_MAX);
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import fa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  op_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [DW-1:0]   opnd_i,
    input  logic [7:0]      flags_i,
    input  logic [IDXW-1:0] bit_sel_i,
    output logic [DW-1:0]   result_o,
    output logic [7:0]      flags_o
);
    alu_op_e       op;
    logic [DW-1:0] ax, ay, asum;
    logic          aci, asub, ah, ac, av;
    logic [DW-1:0] sh_in, sh_res;
    logic          sh_c;
    logic [DW-1:0] dj_res;
    logic          dj_h, dj_c;
    logic          tbit;
    alu_state_t    st_d, st_q;

    assign op = alu_op_e'(op_i);

    // Operand steering for the shared adder
    always_comb begin
        ax   = acc_i;
        ay   = opnd_i;
        aci  = 1'b0;
        asub = 1'b0;
        unique case (op)
            OP_ADC:         aci = flags_i[F_C];
            OP_SUB, OP_CP:  asub = 1'b1;
            OP_SBC:         begin asub = 1'b1; aci = flags_i[F_C]; end
            OP_INC:         begin ax = opnd_i; ay = DW'(1); end
            OP_DEC:         begin ax = opnd_i; ay = DW'(1); asub = 1'b1; end
            OP_NEG:         begin ax = '0; ay = acc_i; asub = 1'b1; end
            default: ;
        endcase
        sh_in = (op inside {OP_RLCA, OP_RRCA, OP_RLA, OP_RRA}) ? acc_i : opnd_i;
        tbit  = opnd_i[bit_sel_i];
    end

    fa_arith u_arith (
        .x_i(ax), .y_i(ay), .ci_i(aci), .sub_i(asub),
        .sum_o(asum), .half_o(ah), .carry_o(ac), .ovf_o(av)
    );

    fa_shift u_shift (
        .op_i(op), .v_i(sh_in), .cin_i(flags_i[F_C]),
        .r_o(sh_res), .cout_o(sh_c)
    );

    fa_daa u_daa (
        .a_i(acc_i), .h_i(flags_i[F_H]), .n_i(flags_i[F_N]), .c_i(flags_i[F_C]),
        .r_o(dj_res), .h_o(dj_h), .c_o(dj_c)
    );

    // Next result and flag byte
    always_comb begin
        st_d.res = acc_i;
        st_d.flg = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                st_d.res = asum;
                st_d.flg = {asum[7], asum == '0, asum[5], ah, asum[3], av, asub, ac};
            end
            OP_CP: begin
                st_d.res = acc_i;
                st_d.flg = {asum[7], asum == '0, opnd_i[5], ah, opnd_i[3], av, 1'b1, ac};
            end
            OP_INC, OP_DEC: begin
                st_d.res = asum;
                st_d.flg = {asum[7], asum == '0, asum[5], ah, asum[3], av, asub, flags_i[F_C]};
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)
                    st_d.res = acc_i & opnd_i;
                else if (op == OP_OR)
                    st_d.res = acc_i | opnd_i;
                else
                    st_d.res = acc_i ^ opnd_i;
                st_d.flg = {st_d.res[7], st_d.res == '0, st_d.res[5], op == OP_AND,
                            st_d.res[3], even_par(st_d.res), 1'b0, 1'b0};
            end
            OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SLL, OP_SRL: begin
                st_d.res = sh_res;
                st_d.flg = {sh_res[7], sh_res == '0, sh_res[5], 1'b0, sh_res[3],
                            even_par(sh_res), 1'b0, sh_c};
            end
            OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: begin
                st_d.res = sh_res;
                st_d.flg = {flags_i[F_S], flags_i[F_Z], sh_res[5], 1'b0, sh_res[3],
                            flags_i[F_PV], 1'b0, sh_c};
            end
            OP_BIT: begin
                st_d.res = acc_i;
                st_d.flg = {tbit && (bit_sel_i == IDXW'(7)), ~tbit,
                            tbit && (bit_sel_i == IDXW'(5)), 1'b1,
                            tbit && (bit_sel_i == IDXW'(3)), ~tbit, 1'b0, flags_i[F_C]};
            end
            OP_DAA: begin
                st_d.res = dj_res;
                st_d.flg = {dj_res[7], dj_res == '0, dj_res[5], dj_h, dj_res[3],
                            even_par(dj_res), flags_i[F_N], dj_c};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.flg;
endmodule

// File: rtl/fa_checker.sv
module fa_checker
    import fa_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  acc_i,
    input logic [DW-1:0]  opnd_i,
    input logic [7:0]     flags_i,
    input logic [DW-1:0]  result_o,
    input logic [7:0]     flags_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else
            seen_q <= 1'b1;
    end

    a_r5_incdec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)
        |-> flags_o[F_C] == $past(flags_i[F_C]));

    a_r7_logic_clears_n_c: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR)
        |-> !flags_o[F_N] && !flags_o[F_C] && (flags_o[F_H] == ($past(op_i) == OP_AND)));

    a_r10_bit_zero_mirrors_pv: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(op_i) == OP_BIT
        |-> flags_o[F_Z] == flags_o[F_PV] && flags_o[F_H] && !flags_o[F_N]
            && result_o == $past(acc_i));

    a_r4_cp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(op_i) == OP_CP
        |-> result_o == $past(acc_i) && flags_o[F_B5] == $past(opnd_i[5])
            && flags_o[F_B3] == $past(opnd_i[3]) && flags_o[F_N]);

    a_r6_neg_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(op_i) == OP_NEG
        |-> flags_o[F_N] && (flags_o[F_C] == ($past(acc_i) != '0)));

    a_r9_rotate_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(op_i) >= OP_RLCA && $past(op_i) <= OP_RRA
        |-> flags_o[F_S] == $past(flags_i[F_S]) && flags_o[F_Z] == $past(flags_i[F_Z])
            && flags_o[F_PV] == $past(flags_i[F_PV]));

    a_r12_undefined_passes: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(op_i) > OP_DAA
        |-> result_o == $past(acc_i) && flags_o == $past(flags_i));
endmodule

bind flag_alu fa_checker u_chk (.*);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    localparam int ADD = 0, ADC = 1, SUB = 2, SBC = 3, CP = 4, INC = 5, DEC = 6, NEG = 7;
    localparam int AND_ = 8, OR_ = 9, XOR_ = 10, RLC = 11, RRC = 12, RL = 13, RR = 14;
    localparam int SLA = 15, SRA = 16, SLL = 17, SRL = 18, RLCA = 19, RRCA = 20;
    localparam int RLA = 21, RRA = 22, BITT = 23, DAA = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc = '0, opnd = '0, fl = '0;
    logic [2:0] bsel = '0;
    logic [7:0] result, flags;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [7:0] r;
        logic [7:0] f;
        string      tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flag_alu dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
        .flags_i(fl), .bit_sel_i(bsel), .result_o(result), .flags_o(flags)
    );

    function automatic logic [7:0] pk(input logic [7:0] r, input bit h, input bit pv,
                                      input bit n, input bit c);
        return {r[7], r == 8'h00, r[5], h, r[3], pv, n, c};
    endfunction

    function automatic bit par(input logic [7:0] v);
        int k = 0;
        for (int i = 0; i < 8; i++) k += v[i];
        return (k % 2) == 0;
    endfunction

    function automatic logic [15:0] model(input int o, input logic [7:0] a, b, f,
                                          input logic [2:0] n);
        logic [7:0] r = a, nf = f, v;
        int ci, s, lo, sv, x, y;
        bit t, c;
        if (o <= NEG) begin
            x = (o == INC || o == DEC) ? int'(b) : (o == NEG ? 0 : int'(a));
            y = (o == INC || o == DEC) ? 1 : (o == NEG ? int'(a) : int'(b));
            ci = (o == ADC || o == SBC) ? int'(f[0]) : 0;
            if (o == ADD || o == ADC || o == INC) begin
                s = x + y + ci; lo = (x % 16) + (y % 16) + ci;
                sv = int'($signed(8'(x))) + int'($signed(8'(y))) + ci;
                r = 8'(s);
                nf = pk(r, lo > 15, sv > 127 || sv < -128, 0, (o == INC) ? f[0] : s > 255);
            end else begin
                s = x - y - ci; lo = (x % 16) - (y % 16) - ci;
                sv = int'($signed(8'(x))) - int'($signed(8'(y))) - ci;
                r = 8'(s);
                nf = pk(r, lo < 0, sv > 127 || sv < -128, 1, (o == DEC) ? f[0] : s < 0);
                if (o == CP) begin nf[5] = b[5]; nf[3] = b[3]; r = a; end
            end
        end else if (o <= XOR_) begin
            r = (o == AND_) ? (a & b) : (o == OR_) ? (a | b) : (a ^ b);
            nf = pk(r, o == AND_, par(r), 0, 0);
        end else if (o <= RRA) begin
            v = (o >= RLCA) ? a : b;
            case (o)
                RLC, RLCA: begin r = {v[6:0], v[7]}; c = v[7]; end
                RRC, RRCA: begin r = {v[0], v[7:1]}; c = v[0]; end
                RL,  RLA:  begin r = {v[6:0], f[0]}; c = v[7]; end
                RR,  RRA:  begin r = {f[0], v[7:1]}; c = v[0]; end
                SLA:       begin r = v << 1; c = v[7]; end
                SLL:       begin r = (v << 1) | 8'h01; c = v[7]; end
                SRA:       begin r = {v[7], v[7:1]}; c = v[0]; end
                default:   begin r = v >> 1; c = v[0]; end
            endcase
            nf = pk(r, 0, par(r), 0, c);
            if (o >= RLCA) begin nf[7] = f[7]; nf[6] = f[6]; nf[2] = f[2]; end
        end else if (o == BITT) begin
            t = b[n];
            nf = {t && n == 7, !t, t && n == 5, 1'b1, t && n == 3, !t, 1'b0, f[0]};
        end else if (o == DAA) begin
            s = 0; c = 0;
            if (f[4] || (a % 16) > 9) s += 6;
            if (f[0] || a > 8'h99) begin s += 96; c = 1; end
            r = f[1] ? 8'(int'(a) - s) : 8'(int'(a) + s);
            nf = pk(r, f[1] ? (f[4] && (a % 16) < 6) : ((a % 16) > 9), par(r), f[1], c);
        end
        return {r, nf};
    endfunction

    function automatic string tag_of(input int o);
        if (o <= ADC) return "R2";
        if (o <= SBC) return "R3";
        if (o == CP) return "R4";
        if (o <= DEC) return "R5";
        if (o == NEG) return "R6";
        if (o <= XOR_) return "R7";
        if (o <= SRL) return "R8";
        if (o <= RRA) return "R9";
        if (o == BITT) return "R10";
        if (o == DAA) return "R11";
        return "R12";
    endfunction

    task automatic drive(input int o, input logic [7:0] a, b, f, input logic [2:0] n);
        logic [15:0] m;
        @(negedge clk);
        op = 5'(o); acc = a; opnd = b; fl = f; bsel = n;
        m = model(o, a, b, f, n);
        q.push_back('{cyc + 1, m[15:8], m[7:0], tag_of(o)});
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            checks++;
            if (result !== e.r || flags !== e.f) begin
                errors++;
                $display("FAIL %s result/flags actual=%h/%h expected=%h/%h",
                         e.tag, result, flags, e.r, e.f);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 5'd0; acc = 8'hFF; opnd = 8'h01; fl = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (result !== 8'h00 || flags !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%h expected=00/00", result, flags);
        end
        rst_n = 1'b1;
        // R2 add: half carry, overflow, zero with carry, carry-in
        drive(ADD, 8'h0F, 8'h01, 8'h00, 0);
        drive(ADD, 8'h7F, 8'h01, 8'h00, 0);
        drive(ADD, 8'hFF, 8'h01, 8'h00, 0);
        drive(ADC, 8'h28, 8'h00, 8'h01, 0);
        // R3 subtract and borrow
        drive(SUB, 8'h00, 8'h01, 8'h00, 0);
        drive(SUB, 8'h80, 8'h01, 8'h00, 0);
        drive(SBC, 8'h10, 8'h0F, 8'h01, 0);
        // R4 compare takes bits 5/3 from the operand
        drive(CP, 8'h10, 8'h28, 8'h00, 0);
        drive(CP, 8'h28, 8'h28, 8'h00, 0);
        // R5 inc/dec keep carry
        drive(INC, 8'h00, 8'h7F, 8'h01, 0);
        drive(INC, 8'h00, 8'hFF, 8'h00, 0);
        drive(DEC, 8'h00, 8'h80, 8'h01, 0);
        drive(DEC, 8'h00, 8'h10, 8'h00, 0);
        // R6 negate
        drive(NEG, 8'h00, 8'h00, 8'hFF, 0);
        drive(NEG, 8'h80, 8'h00, 8'h00, 0);
        drive(NEG, 8'h01, 8'h00, 8'h00, 0);
        // R7 logic
        drive(AND_, 8'hF0, 8'h3C, 8'hFF, 0);
        drive(OR_, 8'h00, 8'h00, 8'hFF, 0);
        drive(XOR_, 8'hAA, 8'h28, 8'hFF, 0);
        // R8 shifts on the operand, including shift-left-set-bit-0
        drive(SLL, 8'h00, 8'h80, 8'h00, 0);
        drive(SLA, 8'h00, 8'h80, 8'h00, 0);
        drive(SRA, 8'h00, 8'h81, 8'h00, 0);
        drive(RL, 8'h00, 8'h40, 8'h01, 0);
        drive(RR, 8'h00, 8'h01, 8'h00, 0);
        // R9 accumulator rotates preserve S, Z, P/V
        drive(RLCA, 8'h81, 8'h00, 8'hC4, 0);
        drive(RRA, 8'h01, 8'h00, 8'h00, 0);
        // R10 bit test over every index, bit set and clear
        for (int i = 0; i < 8; i++) begin
            drive(BITT, 8'h5A, 8'hFF, 8'h01, 3'(i));
            drive(BITT, 8'h5A, 8'h00, 8'h00, 3'(i));
        end
        // R11 decimal adjust after add and after subtract
        drive(DAA, 8'h9A, 8'h00, 8'h00, 0);
        drive(DAA, 8'h15, 8'h00, 8'h10, 0);
        drive(DAA, 8'h0F, 8'h00, 8'h12, 0);
        drive(DAA, 8'hA0, 8'h00, 8'h03, 0);
        drive(DAA, 8'h66, 8'h00, 8'h13, 0);
        // R12 unassigned codes
        drive(25, 8'h3C, 8'hC3, 8'hA5, 0);
        drive(31, 8'h00, 8'hFF, 8'h5A, 7);
        // mixed random traffic over every code
        for (int k = 0; k < 4000; k++)
            drive(int'($urandom_range(31)), 8'($urandom), 8'($urandom), 8'($urandom),
                  3'($urandom));
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule